// File: doc/BRIEF.md
# Separable Round-Robin Switch Allocator

This block matches the input ports of a router crossbar to its output ports. Each clock it takes a request matrix in which every input port marks the outputs it wants. It returns a registered grant matrix that pairs each input with at most one output, and each output with at most one input. The allocator is separable and works input first. A bank of round-robin arbiters, one per input, narrows each input's requests to a single choice. A second bank, one per output, then picks one winner among the inputs that chose that output.

Each arbiter holds a priority pointer. The pointer moves only when that arbiter's pick becomes a final grant, and it then lands just past the winner, so the winner has the lowest priority in the next round. An input arbiter whose choice loses at the output stage keeps its pointer. This spreads the input arbiters over different outputs and reduces conflicts. With more than one pass per cycle, the later passes add matches between inputs and outputs that are still free, and they leave the pointers alone.

The request matrix is a plain level input that is sampled on every clock. The grant matrix is a plain level output. There is no handshake and no back-pressure: a requester that is not granted simply keeps requesting.

Top module: `sep_rr_alloc`

## Requirements
- R1: `gnt` is registered. It reflects the `req` value sampled at the previous rising clock edge, and it is all zero while `rst_n` is low.
- R2: No row of `gnt` has more than one set bit; each input receives at most one output.
- R3: No column of `gnt` has more than one set bit; each output serves at most one input.
- R4: A bit of `gnt` is set only where the same bit of the sampled `req` was set.
- R5: When the sampled `req` has any bit set, `gnt` has at least one bit set.
- R6: The arbiter for an input picks the first requested free output, scanning upward in index from its pointer and wrapping from N_OUT-1 to 0.
- R7: The arbiter for an output grants the first input that chose it, scanning upward in index from its pointer and wrapping from N_IN-1 to 0.
- R8: After reset every pointer is 0, so the lowest-indexed requester wins first.
- R9: When input i is granted output j in the first pass, the pointer of input i becomes (j+1) mod N_OUT and the pointer of output j becomes (i+1) mod N_IN. Every other pointer keeps its value, including the pointer of an input whose choice lost.
- R10: With ITERS greater than 1, each later pass runs the same two stages with the same pointers, restricted to inputs and outputs left unmatched by earlier passes. Later passes never move a pointer.
- R11: Matrix layout: bit i*N_OUT+j of `req` means input i requests output j, and the same bit of `gnt` means input i is granted output j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_IN*N_OUT | Request matrix, row-major by input |
| gnt | output | N_IN*N_OUT | Registered grant matrix, same layout |

## Verification
The bench builds two copies of the block. The first uses the defaults: four inputs, four outputs and a single pass. The second uses three inputs, five outputs and two passes, which brings within reach pointer wrap at sizes that are not powers of two, a non-square matrix, and the second-pass fill of ports left idle by the first pass. Directed patterns cover reset priority, rotation at the input stage and at the output stage, pointer hold on idle and losing arbiters, and single-bit walks of the layout. A long random run is compared against a behavioural model of the pointers on every clock.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  // Width of a pointer that indexes n requesters (at least one bit).
  function automatic int ptr_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_pick.sv
// Combinational round-robin pick: first set request at or above ptr, else wrap.
module rr_pick #(
  parameter int W  = 4,
  parameter int PW = alloc_pkg::ptr_w(W)
) (
  input  logic [W-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [W-1:0]  gnt
);
  logic [W-1:0] upper_mask;
  logic [W-1:0] upper_req;

  for (genvar p = 0; p < W; p++) begin : g_mask
    assign upper_mask[p] = (PW'(p) >= ptr);
  end

  assign upper_req = req & upper_mask;
  // lowest set bit of the upper half, else lowest set bit overall
  assign gnt = (|upper_req) ? (upper_req & (~upper_req + W'(1)))
                            : (req & (~req + W'(1)));
endmodule

// File: rtl/alloc_pass.sv
// One input-first allocation pass over the ports that are still free.
module alloc_pass #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int PWI   = alloc_pkg::ptr_w(N_OUT),
  parameter int PWO   = alloc_pkg::ptr_w(N_IN)
) (
  input  logic [N_IN*N_OUT-1:0] req,
  input  logic [N_IN-1:0]       in_free,
  input  logic [N_OUT-1:0]      out_free,
  input  logic [N_IN*PWI-1:0]   in_ptr,
  input  logic [N_OUT*PWO-1:0]  out_ptr,
  output logic [N_IN*N_OUT-1:0] gnt
);
  localparam int NM = N_IN * N_OUT;

  logic [NM-1:0] pick;      // input-stage choices, row-major
  logic [NM-1:0] col_req;   // transposed, bit j*N_IN+i
  logic [NM-1:0] col_gnt;   // transposed output-stage winners

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    logic [N_OUT-1:0] row_ok;
    assign row_ok = req[i*N_OUT +: N_OUT] & out_free & {N_OUT{in_free[i]}};
    rr_pick #(.W(N_OUT), .PW(PWI)) u_in_arb (
      .req (row_ok),
      .ptr (in_ptr[i*PWI +: PWI]),
      .gnt (pick[i*N_OUT +: N_OUT])
    );
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    for (genvar i = 0; i < N_IN; i++) begin : g_xp
      assign col_req[j*N_IN+i] = pick[i*N_OUT+j];
      assign gnt[i*N_OUT+j]    = col_gnt[j*N_IN+i];
    end
    rr_pick #(.W(N_IN), .PW(PWO)) u_out_arb (
      .req (col_req[j*N_IN +: N_IN]),
      .ptr (out_ptr[j*PWO +: PWO]),
      .gnt (col_gnt[j*N_IN +: N_IN])
    );
  end
endmodule

// File: rtl/sep_rr_alloc.sv
module sep_rr_alloc #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int ITERS = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN*N_OUT-1:0]  req,
  output logic [N_IN*N_OUT-1:0]  gnt
);
  localparam int NM  = N_IN * N_OUT;
  localparam int PWI = alloc_pkg::ptr_w(N_OUT);  // input pointers index outputs
  localparam int PWO = alloc_pkg::ptr_w(N_IN);   // output pointers index inputs

  logic [NM-1:0]        acc [ITERS+1];   // matches accumulated before pass t
  logic [NM-1:0]        pass_g [ITERS];  // matches added by pass t
  logic [N_IN*PWI-1:0]  in_ptr_q, in_ptr_d;
  logic [N_OUT*PWO-1:0] out_ptr_q, out_ptr_d;

  assign acc[0] = '0;

  for (genvar t = 0; t < ITERS; t++) begin : g_pass
    logic [N_IN-1:0]  in_free;
    logic [N_OUT-1:0] out_free;

    always_comb begin
      for (int i = 0; i < N_IN; i++)
        in_free[i] = ~|acc[t][i*N_OUT +: N_OUT];
      for (int j = 0; j < N_OUT; j++) begin
        out_free[j] = 1'b1;
        for (int i = 0; i < N_IN; i++)
          if (acc[t][i*N_OUT+j]) out_free[j] = 1'b0;
      end
    end

    alloc_pass #(.N_IN(N_IN), .N_OUT(N_OUT), .PWI(PWI), .PWO(PWO)) u_pass (
      .req      (req),
      .in_free  (in_free),
      .out_free (out_free),
      .in_ptr   (in_ptr_q),
      .out_ptr  (out_ptr_q),
      .gnt      (pass_g[t])
    );

    assign acc[t+1] = acc[t] | pass_g[t];
  end

  // Pointer update from first-pass grants only.
  for (genvar i = 0; i < N_IN; i++) begin : g_in_ptr
    logic [PWI-1:0] nxt;
    always_comb begin
      nxt = in_ptr_q[i*PWI +: PWI];
      for (int j = 0; j < N_OUT; j++)
        if (pass_g[0][i*N_OUT+j]) nxt = (j == N_OUT-1) ? '0 : PWI'(j+1);
    end
    assign in_ptr_d[i*PWI +: PWI] = nxt;
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_ptr
    logic [PWO-1:0] nxt;
    always_comb begin
      nxt = out_ptr_q[j*PWO +: PWO];
      for (int i = 0; i < N_IN; i++)
        if (pass_g[0][i*N_OUT+j]) nxt = (i == N_IN-1) ? '0 : PWO'(i+1);
    end
    assign out_ptr_d[j*PWO +: PWO] = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt       <= '0;
      in_ptr_q  <= '0;
      out_ptr_q <= '0;
    end else begin
      gnt       <= acc[ITERS];
      in_ptr_q  <= in_ptr_d;
      out_ptr_q <= out_ptr_d;
    end
  end
endmodule

// File: rtl/alloc_chk.sv
module alloc_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int PWI   = 2,
  parameter int PWO   = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_IN*N_OUT-1:0]  req,
  input logic [N_IN*N_OUT-1:0]  gnt,
  input logic [N_IN*PWI-1:0]    in_ptr_q,
  input logic [N_OUT*PWO-1:0]   out_ptr_q
);
  for (genvar i = 0; i < N_IN; i++) begin : g_row
    // R2
    row_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[i*N_OUT +: N_OUT]));
    // R9
    in_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[i*N_OUT +: N_OUT] == '0) |-> $stable(in_ptr_q[i*PWI +: PWI]));
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_col
    logic [N_IN-1:0] col;
    for (genvar i = 0; i < N_IN; i++) begin : g_bit
      assign col[i] = gnt[i*N_OUT+j];
    end
    // R3
    col_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
    // R9
    out_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col == '0) |-> $stable(out_ptr_q[j*PWO +: PWO]));
  end

  // R4
  grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~$past(req)) == '0);

  // R5
  busy_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> (|gnt));
endmodule

bind sep_rr_alloc alloc_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .PWI(PWI), .PWO(PWO)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .gnt       (gnt),
  .in_ptr_q  (in_ptr_q),
  .out_ptr_q (out_ptr_q)
);

// File: tb/sep_rr_alloc_bench.sv
module sep_rr_alloc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] req_a = '0, gnt_a;
  logic [14:0] req_b = '0, gnt_b;

  sep_rr_alloc u_sep_rr_alloc (.clk(clk), .rst_n(rst_n), .req(req_a), .gnt(gnt_a));
  sep_rr_alloc #(.N_IN(3), .N_OUT(5), .ITERS(2)) u_sep_rr_alloc_b (
    .clk(clk), .rst_n(rst_n), .req(req_b), .gnt(gnt_b));

  int checks = 0;
  int errors = 0;
  int in_p [2][8];
  int out_p [2][8];
  logic [63:0] exp_a = '0, exp_b = '0, prev_a = '0, prev_b = '0;

  localparam logic [63:0] MASK_A = 64'hFFFF;
  localparam logic [63:0] MASK_B = 64'h7FFF;

  // Behavioural model of the allocation described in R6..R10.
  task automatic model(input int d, input int n, input int m, input int iters,
                       input logic [63:0] r, output logic [63:0] g);
    int choice [8];
    bit im [8];
    bit om [8];
    int nip [8];
    int nop [8];
    bit found;
    g = '0;
    for (int x = 0; x < 8; x++) begin
      im[x] = 0; om[x] = 0; nip[x] = in_p[d][x]; nop[x] = out_p[d][x];
    end
    for (int t = 0; t < iters; t++) begin
      for (int i = 0; i < n; i++) begin
        choice[i] = -1;
        found = 0;
        if (!im[i])
          for (int k = 0; k < m; k++) begin
            int j = (in_p[d][i] + k) % m;
            if (!found && r[i*m+j] && !om[j]) begin choice[i] = j; found = 1; end
          end
      end
      for (int j = 0; j < m; j++) begin
        found = 0;
        if (!om[j])
          for (int k = 0; k < n; k++) begin
            int i = (out_p[d][j] + k) % n;
            if (!found && choice[i] == j) begin
              found = 1;
              g[i*m+j] = 1'b1;
              im[i] = 1; om[j] = 1;
              if (t == 0) begin nop[j] = (i + 1) % n; nip[i] = (j + 1) % m; end
            end
          end
      end
    end
    for (int x = 0; x < 8; x++) begin in_p[d][x] = nip[x]; out_p[d][x] = nop[x]; end
  endtask

  task automatic compare(input string tag, input int d, input logic [63:0] act,
                         input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dut%0d gnt actual %h expected %h", tag, d, act, exp);
    end
  endtask

  // Structural properties of the observed grant matrix (R2..R5).
  task automatic props(input int d, input int n, input int m,
                       input logic [63:0] g, input logic [63:0] pr);
    for (int i = 0; i < n; i++) begin
      int c = 0;
      for (int j = 0; j < m; j++) c += g[i*m+j];
      checks++;
      if (c > 1) begin errors++;
        $display("FAIL R2 dut%0d row %0d actual %0d grants expected <=1", d, i, c); end
    end
    for (int j = 0; j < m; j++) begin
      int c = 0;
      for (int i = 0; i < n; i++) c += g[i*m+j];
      checks++;
      if (c > 1) begin errors++;
        $display("FAIL R3 dut%0d col %0d actual %0d grants expected <=1", d, j, c); end
    end
    checks++;
    if ((g & ~pr) != 0) begin errors++;
      $display("FAIL R4 dut%0d actual %h expected subset of %h", d, g, pr); end
    checks++;
    if (pr != 0 && g == 0) begin errors++;
      $display("FAIL R5 dut%0d actual %h expected nonzero", d, g); end
  endtask

  task automatic step(input logic [63:0] ra, input logic [63:0] rb, input string tag);
    @(negedge clk);
    compare(tag, 0, {48'b0, gnt_a}, exp_a);
    props(0, 4, 4, {48'b0, gnt_a}, prev_a);
    compare(tag, 1, {49'b0, gnt_b}, exp_b);
    props(1, 3, 5, {49'b0, gnt_b}, prev_b);
    model(0, 4, 4, 1, ra & MASK_A, exp_a);
    model(1, 3, 5, 2, rb & MASK_B, exp_b);
    prev_a = ra & MASK_A;
    prev_b = rb & MASK_B;
    req_a = ra[15:0];
    req_b = rb[14:0];
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog requirement none actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int x = 0; x < 8; x++) begin in_p[d][x] = 0; out_p[d][x] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    compare("R1", 0, {48'b0, gnt_a}, '0);
    compare("R1", 1, {49'b0, gnt_b}, '0);
    rst_n = 1'b1;

    // R8: all pointers at 0, lowest index wins first
    step('1, '1, "R8");
    step('0, '0, "R8");

    // R6: input 0 wants outputs 1 and 3 -> alternates
    for (int k = 0; k < 6; k++) step(64'h000A, 64'h000A, "R6");

    // R7: every input wants output 2 -> inputs rotate
    for (int k = 0; k < 8; k++) step(64'h4444, 64'h0084 | 64'h1000, "R7");

    // R9: full contention, then idle (pointers hold), then full again
    for (int k = 0; k < 8; k++) step('1, '1, "R9");
    for (int k = 0; k < 3; k++) step('0, '0, "R9");
    for (int k = 0; k < 4; k++) step('1, '1, "R9");

    // R11: walk a single request bit through the layout
    for (int k = 0; k < 16; k++) step(64'd1 << k, 64'd1 << (k % 15), "R11");

    // R10: second pass fills ports left idle in the three-by-five copy
    for (int k = 0; k < 6; k++) step(64'h0, 64'h7FFF, "R10");
    for (int k = 0; k < 6; k++) step(64'h0, 64'h0C63, "R10");

    // R1: long random run against the model, varying density
    for (int k = 0; k < 600; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (k % 3 == 1) begin ra &= {$urandom, $urandom}; rb &= {$urandom, $urandom}; end
      if (k % 3 == 2) begin ra |= {$urandom, $urandom}; rb |= {$urandom, $urandom}; end
      step(ra, rb, "R1");
    end
    step('0, '0, "R1");

    summary();
    $finish;
  end
endmodule